// File: doc/BRIEF.md
# Two-Processor Shared-Memory Mailbox

This block is a single word-wide storage array placed between two processors that cannot share a bus directly. Each processor gets its own synchronous access port with a request, a write enable, an address, write data, a grant and read data. Both ports reach the same array. The first processor, side A, is the time-critical one, so it is never held off. Side B is served only in cycles that side A leaves free.

The address space is split into two directional halves. The lower half carries traffic from B to A, and the upper half carries traffic from A to B. The first word of each half is a command word. A non-zero value there means a message is waiting. A sender fills the data words of its outbound half and then posts a non-zero command. The receiver copies the payload and writes zero to the command word to hand it back. The sender polls until the word reads zero.

The block follows both command words in registers. From them it drives, per side, a pending level, an acknowledge flag and a sticky timeout flag, so a sender can detect a peer that never answers. The two processors order the bytes of a word oppositely, so the block exchanges the two byte lanes on side B's data paths.

Top module: `mailbox_bridge`

## Requirements
- R1: After reset, all six status outputs are low, and both command words (address 0 and address 2^(ADDR_W-1), i.e. 1024 by default) read as zero from either side.
- R2: A request from side A is granted in the same cycle. For every granted read on either side, the read data is valid on the first clock edge after the grant and holds until the next granted read on that side.
- R3: While aReq is high, bGnt is low. A side-B request is granted in the first cycle in which aReq is low, and side B must hold its request until granted.
- R4: When both sides write the same address in the same cycle, side A's write takes effect first and side B's write takes effect in B's later grant cycle. The word then holds B's data.
- R5: On side B, bits [15:8] and [7:0] are exchanged on both writes and reads. A word written by B as 0xABCD reads 0xCDAB on side A and 0xABCD on side B, and a word written by A as 0x1234 reads 0x3412 on side B.
- R6: aMailPending is high exactly while the command word at address 0 (B-to-A half) is non-zero. bMailPending is high exactly while the command word at address 1024 (A-to-B half) is non-zero. Each changes on the clock edge that performs the write.
- R7: A receiver writing zero to its inbound command word drops that side's pending level on the same edge, and the sender then reads the word as zero.
- R8: aMailAck (bMailAck) sets when side B (A) writes zero to side A's (B's) non-zero outbound command word. It clears when the owner writes its own outbound command word.
- R9: A sender's timeout flag (aTimeout for address 1024, bTimeout for address 0) rises exactly toLimit clock edges after the edge that wrote a non-zero command, if the word has not been written since. A toLimit of 0 disables the timeout.
- R10: A raised timeout flag stays high, even if the receiver clears the word afterwards, until the sender writes its own command word.
- R11: If the receiver clears the command word before the limit is reached, the sender's timeout flag does not rise.
- R12: Ordinary data words anywhere in either half store and return the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| toLimit | input | TO_W | Timeout limit in cycles, 0 disables |
| aReq | input | 1 | Side A access request |
| aWe | input | 1 | Side A write enable |
| aAddr | input | ADDR_W | Side A word address |
| aWdata | input | DATA_W | Side A write data |
| aGnt | output | 1 | Side A grant |
| aRdata | output | DATA_W | Side A read data, one cycle after grant |
| aMailPending | output | 1 | B-to-A command word non-zero |
| aMailAck | output | 1 | Side A's posted command was cleared by B |
| aTimeout | output | 1 | Side A's posted command was not cleared in time |
| bReq | input | 1 | Side B access request |
| bWe | input | 1 | Side B write enable |
| bAddr | input | ADDR_W | Side B word address |
| bWdata | input | DATA_W | Side B write data (opposite byte order) |
| bGnt | output | 1 | Side B grant |
| bRdata | output | DATA_W | Side B read data (opposite byte order) |
| bMailPending | output | 1 | A-to-B command word non-zero |
| bMailAck | output | 1 | Side B's posted command was cleared by A |
| bTimeout | output | 1 | Side B's posted command was not cleared in time |

## Verification
The bench drives both ports into the same cycle and the same address. A design that let B win, or that granted both sides, would leave A's data in the word or show bGnt high next to aGnt. Asymmetric byte patterns written from one side and read from the other expose a swap that is missing, doubled, or applied in only one direction. The timeout is sampled one edge before and exactly at the limit to catch off-by-one counting. The bench also checks that the flag stays high after the receiver clears the word and drops when the sender writes again, and that a limit of zero never fires.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // a granted write happens this cycle
    logic rdA;    // a granted read for side A
    logic rdB;    // a granted read for side B
    logic selB;   // side B owns the array this cycle
  } memStrb_t;

  localparam int NUM_SLOTS = 2;

endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DATA_W = 16,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrHit,
  input  logic              bySender,
  input  logic [DATA_W-1:0] wrWord,
  input  logic [TO_W-1:0]   limit,
  output logic [DATA_W-1:0] cmdWord,
  output logic              pending,
  output logic              acked,
  output logic              timedOut
);

  logic [TO_W-1:0] cnt;
  logic [TO_W-1:0] cntNext;

  assign cntNext = cnt + 1'b1;
  assign pending = (cmdWord != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdWord  <= '0;
      cnt      <= '0;
      timedOut <= 1'b0;
      acked    <= 1'b0;
    end else if (wrHit) begin
      cmdWord <= wrWord;
      cnt     <= '0;
      if (bySender) begin
        timedOut <= 1'b0;
        acked    <= 1'b0;
      end else if (pending && wrWord == '0) begin
        acked <= 1'b1;
      end
    end else if (pending && cnt != limit) begin
      cnt <= cntNext;
      if (cntNext == limit) timedOut <= 1'b1;
    end
  end

  AST_TO_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    timedOut && !(wrHit && bySender) |=> timedOut); // R10
  AST_TO_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timedOut) |-> pending); // R9
  AST_ACK_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    $rose(acked) |-> !pending); // R8

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int TO_W   = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [TO_W-1:0]                 toLimit,
  input  logic                            aReq,
  input  logic                            aWe,
  input  logic                            bReq,
  input  logic                            bWe,
  input  logic [ADDR_W-1:0]               accAddr,
  input  logic [DATA_W-1:0]               wrWord,
  output logic                            aGnt,
  output logic                            bGnt,
  output memStrb_t                        strb,
  output logic [NUM_SLOTS-1:0][DATA_W-1:0] cmdWords,
  output logic                            aMailPending,
  output logic                            bMailPending,
  output logic                            aMailAck,
  output logic                            bMailAck,
  output logic                            aTimeout,
  output logic                            bTimeout
);

  localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};

  logic [NUM_SLOTS-1:0] pend;
  logic [NUM_SLOTS-1:0] ack;
  logic [NUM_SLOTS-1:0] tout;

  // Fixed priority: side A always wins
  always_comb begin
    aGnt      = aReq;
    bGnt      = bReq && !aReq;
    strb.selB = bGnt;
    strb.wrEn = aGnt ? aWe : (bGnt && bWe);
    strb.rdA  = aGnt && !aWe;
    strb.rdB  = bGnt && !bWe;
  end

  // Slot 0: lower half, B sends to A. Slot 1: upper half, A sends to B.
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : gSlot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = (i == 0) ? '0 : HALF_BASE;
    localparam bit SENDER_IS_B = (i == 0);

    logic hit;
    logic fromSender;
    assign hit        = strb.wrEn && (accAddr == SLOT_ADDR);
    assign fromSender = SENDER_IS_B ? strb.selB : !strb.selB;

    mbx_slot #(.DATA_W(DATA_W), .TO_W(TO_W)) uSlot (
      .clk      (clk),
      .rstN     (rstN),
      .wrHit    (hit),
      .bySender (fromSender),
      .wrWord   (wrWord),
      .limit    (toLimit),
      .cmdWord  (cmdWords[i]),
      .pending  (pend[i]),
      .acked    (ack[i]),
      .timedOut (tout[i])
    );
  end

  assign aMailPending = pend[0];
  assign bMailPending = pend[1];
  assign aMailAck     = ack[1];
  assign bMailAck     = ack[0];
  assign aTimeout     = tout[1];
  assign bTimeout     = tout[0];

  AST_PEND_ON_POST: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn && accAddr == '0 && wrWord != '0 |=> aMailPending); // R6
  AST_PEND_ON_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn && accAddr == HALF_BASE && wrWord == '0 |=> !bMailPending); // R7

endmodule

// File: rtl/mbx_dpath.sv
module mbx_dpath
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  memStrb_t                         strb,
  input  logic [ADDR_W-1:0]                aAddr,
  input  logic [DATA_W-1:0]                aWdata,
  input  logic [ADDR_W-1:0]                bAddr,
  input  logic [DATA_W-1:0]                bWdata,
  input  logic [NUM_SLOTS-1:0][DATA_W-1:0] cmdWords,
  output logic [ADDR_W-1:0]                accAddr,
  output logic [DATA_W-1:0]                wrWord,
  output logic [DATA_W-1:0]                aRdata,
  output logic [DATA_W-1:0]                bRdata
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int HALF  = DATA_W / 2;
  localparam logic [ADDR_W-1:0] HALF_BASE = {1'b1, {(ADDR_W-1){1'b0}}};

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rawRd;
  logic [DATA_W-1:0] bIn;
  logic [DATA_W-1:0] bOut;

  // Byte-lane exchange for side B
  assign bIn  = {bWdata[HALF-1:0], bWdata[DATA_W-1:HALF]};
  assign bOut = {rawRd[HALF-1:0], rawRd[DATA_W-1:HALF]};

  assign accAddr = strb.selB ? bAddr : aAddr;
  assign wrWord  = strb.selB ? bIn : aWdata;

  // Command words live in reset registers, the array covers the rest
  always_comb begin
    if (accAddr == '0)             rawRd = cmdWords[0];
    else if (accAddr == HALF_BASE) rawRd = cmdWords[1];
    else                           rawRd = mem[accAddr];
  end

  always_ff @(posedge clk) begin
    if (strb.wrEn) mem[accAddr] <= wrWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aRdata <= '0;
      bRdata <= '0;
    end else begin
      if (strb.rdA) aRdata <= rawRd;
      if (strb.rdB) bRdata <= bOut;
    end
  end

  AST_RD_HOLD_A: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdA |=> $stable(aRdata)); // R2
  AST_RD_HOLD_B: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdB |=> $stable(bRdata)); // R2

endmodule

// File: rtl/mailbox_bridge.sv
module mailbox_bridge
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int TO_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TO_W-1:0]   toLimit,
  input  logic              aReq,
  input  logic              aWe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic              aGnt,
  output logic [DATA_W-1:0] aRdata,
  output logic              aMailPending,
  output logic              aMailAck,
  output logic              aTimeout,
  input  logic              bReq,
  input  logic              bWe,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic              bGnt,
  output logic [DATA_W-1:0] bRdata,
  output logic              bMailPending,
  output logic              bMailAck,
  output logic              bTimeout
);

  memStrb_t                         strb;
  logic [ADDR_W-1:0]                accAddr;
  logic [DATA_W-1:0]                wrWord;
  logic [NUM_SLOTS-1:0][DATA_W-1:0] cmdWords;

  mbx_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TO_W(TO_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .toLimit      (toLimit),
    .aReq         (aReq),
    .aWe          (aWe),
    .bReq         (bReq),
    .bWe          (bWe),
    .accAddr      (accAddr),
    .wrWord       (wrWord),
    .aGnt         (aGnt),
    .bGnt         (bGnt),
    .strb         (strb),
    .cmdWords     (cmdWords),
    .aMailPending (aMailPending),
    .bMailPending (bMailPending),
    .aMailAck     (aMailAck),
    .bMailAck     (bMailAck),
    .aTimeout     (aTimeout),
    .bTimeout     (bTimeout)
  );

  mbx_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .aAddr    (aAddr),
    .aWdata   (aWdata),
    .bAddr    (bAddr),
    .bWdata   (bWdata),
    .cmdWords (cmdWords),
    .accAddr  (accAddr),
    .wrWord   (wrWord),
    .aRdata   (aRdata),
    .bRdata   (bRdata)
  );

  AST_A_NO_WAIT_B: assert property (@(posedge clk) disable iff (!rstN)
    aReq && bReq |=> !$past(bGnt)); // R3

endmodule

// File: tb/sim_mailbox_bridge.sv
`timescale 1ns/1ps
module sim_mailbox_bridge;

  localparam int ADDR_W = 11;
  localparam int DATA_W = 16;
  localparam int TO_W   = 16;
  localparam logic [ADDR_W-1:0] CMD_BA = 11'd0;
  localparam logic [ADDR_W-1:0] CMD_AB = 11'd1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [TO_W-1:0] toLimit = 16'd1000;
  logic aReq = 1'b0, aWe = 1'b0, bReq = 1'b0, bWe = 1'b0;
  logic [ADDR_W-1:0] aAddr = '0, bAddr = '0;
  logic [DATA_W-1:0] aWdata = '0, bWdata = '0;
  logic aGnt, bGnt, aMailPending, bMailPending, aMailAck, bMailAck, aTimeout, bTimeout;
  logic [DATA_W-1:0] aRdata, bRdata;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mailbox_bridge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TO_W(TO_W)) u0 (
    .clk(clk), .rstN(rstN), .toLimit(toLimit),
    .aReq(aReq), .aWe(aWe), .aAddr(aAddr), .aWdata(aWdata), .aGnt(aGnt),
    .aRdata(aRdata), .aMailPending(aMailPending), .aMailAck(aMailAck), .aTimeout(aTimeout),
    .bReq(bReq), .bWe(bWe), .bAddr(bAddr), .bWdata(bWdata), .bGnt(bGnt),
    .bRdata(bRdata), .bMailPending(bMailPending), .bMailAck(bMailAck), .bTimeout(bTimeout)
  );

  function automatic void check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endfunction

  // Scoreboard queues
  logic [DATA_W-1:0] expA[$];
  logic [DATA_W-1:0] expB[$];
  string tagA[$];
  string tagB[$];
  logic aRdIss = 1'b0, bRdIss = 1'b0;

  always @(posedge clk) begin
    aRdIss <= aReq && aGnt && !aWe;
    bRdIss <= bReq && bGnt && !bWe;
  end

  always @(negedge clk) begin
    if (aRdIss) begin
      if (expA.size() == 0) check("R2 unexpected A read", 1, 0);
      else check(tagA.pop_front(), aRdata, expA.pop_front());
    end
    if (bRdIss) begin
      if (expB.size() == 0) check("R2 unexpected B read", 1, 0);
      else check(tagB.pop_front(), bRdata, expB.pop_front());
    end
  end

  task automatic accA(input logic we, input logic [ADDR_W-1:0] ad,
                      input logic [DATA_W-1:0] d, input string tag);
    @(negedge clk);
    aReq = 1'b1; aWe = we; aAddr = ad; aWdata = we ? d : '0;
    if (!we) begin expA.push_back(d); tagA.push_back(tag); end
    @(negedge clk);
    aReq = 1'b0; aWe = 1'b0;
  endtask

  task automatic accB(input logic we, input logic [ADDR_W-1:0] ad,
                      input logic [DATA_W-1:0] d, input string tag);
    @(negedge clk);
    bReq = 1'b1; bWe = we; bAddr = ad; bWdata = we ? d : '0;
    if (!we) begin expB.push_back(d); tagB.push_back(tag); end
    do @(posedge clk); while (!bGnt);
    @(negedge clk);
    bReq = 1'b0; bWe = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      check("watchdog expired", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 status after reset",
          {aMailPending, bMailPending, aMailAck, bMailAck, aTimeout, bTimeout}, 0);
    accA(0, CMD_BA, 16'h0000, "R1 cmd B->A reads zero");
    accB(0, CMD_AB, 16'h0000, "R1 cmd A->B reads zero");

    // R5 / R12 data words and byte swap
    accA(1, 11'd5, 16'h1234, "");
    accB(0, 11'd5, 16'h3412, "R5 A write seen swapped on B");
    accB(1, 11'd1500, 16'hABCD, "");
    accB(0, 11'd1500, 16'hABCD, "R5 B reads own write");
    accA(0, 11'd1500, 16'hCDAB, "R5 B write seen swapped on A");
    accA(1, 11'd1023, 16'h00FF, "");
    accA(1, 11'd2047, 16'h8001, "");
    accA(0, 11'd1023, 16'h00FF, "R12 top of lower half");
    accA(0, 11'd2047, 16'h8001, "R12 top of upper half");

    // R2 / R3 / R4 same-cycle writes to one address
    @(negedge clk);
    aReq = 1; aWe = 1; aAddr = 11'd9; aWdata = 16'h1111;
    bReq = 1; bWe = 1; bAddr = 11'd9; bWdata = 16'h2233;
    #1;
    check("R2 A granted at once", aGnt, 1);
    check("R3 B held off under A", bGnt, 0);
    @(negedge clk);
    aReq = 0; aWe = 0;
    #1;
    check("R3 B granted when A idle", bGnt, 1);
    @(negedge clk);
    bReq = 0; bWe = 0;
    accA(0, 11'd9, 16'h3322, "R4 B data lands last");

    // R6 posting in both directions
    accA(1, CMD_AB, 16'h0102, "");
    check("R6 B pending after A posts", bMailPending, 1);
    check("R6 A not pending", aMailPending, 0);
    accB(0, CMD_AB, 16'h0201, "R6 B reads A command swapped");
    accB(1, CMD_BA, 16'h0007, "");
    check("R6 A pending after B posts", aMailPending, 1);
    accA(0, CMD_BA, 16'h0700, "R6 A reads B command");

    // R7 / R8 receiver clears
    accA(1, CMD_BA, 16'h0000, "");
    check("R7 A pending drops on clear", aMailPending, 0);
    check("R8 B ack set", bMailAck, 1);
    accB(0, CMD_BA, 16'h0000, "R7 sender sees zero");
    accB(1, CMD_AB, 16'h0000, "");
    check("R7 B pending drops on clear", bMailPending, 0);
    check("R8 A ack set", aMailAck, 1);
    accA(1, CMD_AB, 16'h0055, "");
    check("R8 A ack cleared by new post", aMailAck, 0);
    accB(1, CMD_AB, 16'h0000, "");
    accB(1, CMD_BA, 16'h0011, "");
    check("R8 B ack cleared by new post", bMailAck, 0);
    accA(1, CMD_BA, 16'h0000, "");

    // R9 / R10 timeout
    toLimit = 16'd20;
    accA(1, CMD_AB, 16'h0009, "");
    idle(19);
    check("R9 no timeout one edge early", aTimeout, 0);
    idle(1);
    check("R9 timeout at limit", aTimeout, 1);
    check("R9 other side quiet", bTimeout, 0);
    idle(5);
    accB(1, CMD_AB, 16'h0000, "");
    check("R10 timeout sticky after receiver clear", aTimeout, 1);
    accA(1, CMD_AB, 16'h0000, "");
    check("R10 timeout cleared by sender write", aTimeout, 0);

    // R11 clear in time
    accB(1, CMD_BA, 16'h0100, "");
    idle(10);
    accA(1, CMD_BA, 16'h0000, "");
    idle(30);
    check("R11 no timeout when cleared in time", bTimeout, 0);
    check("R11 ack after timely clear", bMailAck, 1);

    // R9 limit zero disables
    toLimit = 16'd0;
    accB(1, CMD_BA, 16'h0001, "");
    idle(40);
    check("R9 limit zero never fires", bTimeout, 0);
    check("R6 still pending", aMailPending, 1);

    idle(3);
    check("R2 all reads returned", expA.size() + expB.size(), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule